// File: doc/BRIEF.md
# Link Configuration Validator with Drive Code Lookup

This block screens a requested serial-link configuration before it reaches the transmitter. A request carries a rate code, a lane count and a swing level and a pre-emphasis level for each lane. It also carries two flags that say whether the rate and the drive levels are being changed. The block either rejects the request or turns each active lane's swing and pre-emphasis pair into three drive codes for the analog front end: amplitude, amplitude scale and emphasis.

The mapping from a level pair to drive codes is a small, uneven table. The amplitude does not grow evenly with the levels, and the emphasis can drop as the levels rise. Pairs whose swing plus pre-emphasis exceeds three have no entry and are rejected. The checks and the lookup are combinational. The verdict and the codes are registered when a request strobe is seen and are held until the next strobe. A single-cycle done pulse marks each new result.

Top module: `link_cfg_check`

## Requirements
- R1: While reset is held and after reset until the first request, `rsp_done` and `rsp_err` are 0 and every drive code output is 0.
- R2: A request sampled with `req_vld` high at a clock edge gives `rsp_done`=1 in the following cycle only. `rsp_err` and the drive codes keep their values while no request is made.
- R3: With `req_rate_chg`=1, only the rate codes 0x654 and 0xA8C are accepted and any other code sets `rsp_err`. With `req_rate_chg`=0, the rate code has no effect on the result.
- R4: A lane count other than 1, 2 or 4 sets `rsp_err`, whatever the change flags are.
- R5: With `req_drv_chg`=1, a request is rejected when any active lane has swing above 3, pre-emphasis above 3, or swing plus pre-emphasis above 3.
- R6: For an accepted request with `req_drv_chg`=1, active lane i shows its amplitude code in `rsp_amp[3i+2:3i]` and its emphasis code in `rsp_emph[4i+3:4i]`, as listed below as (swing,pre) → amplitude/emphasis. Swing 0 gives (0,0)→1/0x0, (0,1)→2/0x4, (0,2)→3/0x8 and (0,3)→4/0xD. Swing 1 gives (1,0)→3/0x0, (1,1)→5/0x7 and (1,2)→6/0x6. Swing 2 gives (2,0)→5/0x0 and (2,1)→7/0x4. Swing 3 gives (3,0)→7/0x0.
- R7: For an accepted request with `req_drv_chg`=1, every active lane's amplitude scale `rsp_scale[2i+1:2i]` is 1.
- R8: Lanes whose index is at or above the lane count always output zero codes. Their levels are not checked.
- R9: When a request is rejected, or when `req_drv_chg`=0, all drive code outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request strobe |
| req_rate_chg | input | 1 | Rate is being changed; enables the rate check |
| req_rate | input | RATE_W | Requested rate code |
| req_lanes | input | CNT_W | Requested lane count |
| req_drv_chg | input | 1 | Drive levels are being changed; enables the level check and lookup |
| req_swing | input | NUM_LANES*LVL_W | Per-lane swing level, lane i in bits [LVL_W*i +: LVL_W] |
| req_preemph | input | NUM_LANES*LVL_W | Per-lane pre-emphasis level, same packing |
| rsp_done | output | 1 | One-cycle pulse when a new result is registered |
| rsp_err | output | 1 | Last request was rejected |
| rsp_amp | output | NUM_LANES*3 | Per-lane amplitude codes |
| rsp_scale | output | NUM_LANES*2 | Per-lane amplitude scale codes |
| rsp_emph | output | NUM_LANES*4 | Per-lane emphasis codes |

## Verification
The bench builds the block with its default parameters: four lanes, 3-bit level fields, a 3-bit lane count and a 12-bit rate code. With 3-bit level fields, levels 4 to 7 can be driven, so the out-of-range rejection is reachable. With a 3-bit lane count, every count from 0 to 7 is swept, covering each invalid count. On each lane in turn, all 64 swing and pre-emphasis pairs are driven while the other lanes stay valid. This covers every table entry and every rejected pair at every lane position. Separate cases mix inactive lanes that carry illegal levels with valid active lanes, and check the rate codes on either side of the two accepted values.

// File: rtl/lcv_pkg.sv
package lcv_pkg;

  localparam int AMP_W   = 3;
  localparam int SCALE_W = 2;
  localparam int EMPH_W  = 4;
  localparam int MAX_LVL = 3;

  localparam logic [31:0] RATE_CODE_LO = 32'h0000_0654;
  localparam logic [31:0] RATE_CODE_HI = 32'h0000_0A8C;

  typedef struct packed {
    logic [AMP_W-1:0]   amp;
    logic [SCALE_W-1:0] scale;
    logic [EMPH_W-1:0]  emph;
  } drv_t;

  function automatic logic rate_code_ok(input logic [31:0] code);
    return (code == RATE_CODE_LO) || (code == RATE_CODE_HI);
  endfunction

  function automatic logic lane_cnt_ok(input int unsigned n, input int unsigned max_n);
    return ((n == 1) || (n == 2) || (n == 4)) && (n <= max_n);
  endfunction

  function automatic logic lvl_pair_ok(input int unsigned sw, input int unsigned pe);
    return (sw <= MAX_LVL) && (pe <= MAX_LVL) && ((sw + pe) <= MAX_LVL);
  endfunction

  // Lookup for an allowed pair; illegal pairs return zero codes.
  function automatic drv_t drv_lookup(input int unsigned sw, input int unsigned pe);
    drv_t d;
    d = '0;
    if (lvl_pair_ok(sw, pe)) begin
      d.scale = SCALE_W'(1);
      unique case ((sw << 2) | pe)
        0:  begin d.amp = AMP_W'(1); d.emph = EMPH_W'(4'h0); end
        1:  begin d.amp = AMP_W'(2); d.emph = EMPH_W'(4'h4); end
        2:  begin d.amp = AMP_W'(3); d.emph = EMPH_W'(4'h8); end
        3:  begin d.amp = AMP_W'(4); d.emph = EMPH_W'(4'hD); end
        4:  begin d.amp = AMP_W'(3); d.emph = EMPH_W'(4'h0); end
        5:  begin d.amp = AMP_W'(5); d.emph = EMPH_W'(4'h7); end
        6:  begin d.amp = AMP_W'(6); d.emph = EMPH_W'(4'h6); end
        8:  begin d.amp = AMP_W'(5); d.emph = EMPH_W'(4'h0); end
        9:  begin d.amp = AMP_W'(7); d.emph = EMPH_W'(4'h4); end
        12: begin d.amp = AMP_W'(7); d.emph = EMPH_W'(4'h0); end
        default: d = '0;
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/lcv_req_chk.sv
module lcv_req_chk
  import lcv_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int RATE_W    = 12,
  parameter int CNT_W     = 3
) (
  input  logic                 rate_chg,
  input  logic [RATE_W-1:0]    rate,
  input  logic [CNT_W-1:0]     lanes,
  output logic                 rate_bad,
  output logic                 lanes_bad,
  output logic [NUM_LANES-1:0] lane_act
);

  logic rate_hit;
  logic cnt_hit;

  assign rate_hit  = rate_code_ok(32'(rate));
  assign cnt_hit   = lane_cnt_ok(int'(lanes), NUM_LANES);
  assign rate_bad  = rate_chg && !rate_hit;
  assign lanes_bad = !cnt_hit;

  // Thermometer mask of active lanes; empty when the count is invalid.
  always_comb begin
    for (int i = 0; i < NUM_LANES; i++) begin
      lane_act[i] = cnt_hit && (int'(lanes) > i);
    end
  end

endmodule

// File: rtl/lcv_lane_map.sv
module lcv_lane_map
  import lcv_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             active,
  input  logic             drv_chg,
  input  logic [LVL_W-1:0] swing,
  input  logic [LVL_W-1:0] preemph,
  output logic             lvl_bad,
  output drv_t             drv
);

  logic checked;
  logic pair_ok;
  drv_t table_drv;

  assign checked   = active && drv_chg;
  assign pair_ok   = lvl_pair_ok(int'(swing), int'(preemph));
  assign table_drv = drv_lookup(int'(swing), int'(preemph));
  assign lvl_bad   = checked && !pair_ok;
  assign drv       = (checked && pair_ok) ? table_drv : '0;

endmodule

// File: rtl/link_cfg_check.sv
module link_cfg_check
  import lcv_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int RATE_W    = 12,
  parameter int CNT_W     = 3,
  parameter int LVL_W     = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_vld,
  input  logic                         req_rate_chg,
  input  logic [RATE_W-1:0]            req_rate,
  input  logic [CNT_W-1:0]             req_lanes,
  input  logic                         req_drv_chg,
  input  logic [NUM_LANES*LVL_W-1:0]   req_swing,
  input  logic [NUM_LANES*LVL_W-1:0]   req_preemph,
  output logic                         rsp_done,
  output logic                         rsp_err,
  output logic [NUM_LANES*AMP_W-1:0]   rsp_amp,
  output logic [NUM_LANES*SCALE_W-1:0] rsp_scale,
  output logic [NUM_LANES*EMPH_W-1:0]  rsp_emph
);

  localparam int SUM_W = LVL_W + 1;

  logic                 rate_bad;
  logic                 lanes_bad;
  logic [NUM_LANES-1:0] lane_act;
  logic [NUM_LANES-1:0] lvl_bad;
  logic                 req_err;
  drv_t                 lane_drv [NUM_LANES];

  lcv_req_chk #(
    .NUM_LANES(NUM_LANES),
    .RATE_W   (RATE_W),
    .CNT_W    (CNT_W)
  ) u_req_chk (
    .rate_chg (req_rate_chg),
    .rate     (req_rate),
    .lanes    (req_lanes),
    .rate_bad (rate_bad),
    .lanes_bad(lanes_bad),
    .lane_act (lane_act)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    lcv_lane_map #(
      .LVL_W(LVL_W)
    ) u_map (
      .active (lane_act[g]),
      .drv_chg(req_drv_chg),
      .swing  (req_swing[g*LVL_W +: LVL_W]),
      .preemph(req_preemph[g*LVL_W +: LVL_W]),
      .lvl_bad(lvl_bad[g]),
      .drv    (lane_drv[g])
    );
  end

  assign req_err = rate_bad || lanes_bad || (|lvl_bad);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_amp   <= '0;
      rsp_scale <= '0;
      rsp_emph  <= '0;
    end else begin
      rsp_done <= req_vld;
      if (req_vld) begin
        rsp_err <= req_err;
        for (int i = 0; i < NUM_LANES; i++) begin
          rsp_amp[i*AMP_W +: AMP_W]       <= req_err ? '0 : lane_drv[i].amp;
          rsp_scale[i*SCALE_W +: SCALE_W] <= req_err ? '0 : lane_drv[i].scale;
          rsp_emph[i*EMPH_W +: EMPH_W]    <= req_err ? '0 : lane_drv[i].emph;
        end
      end
    end
  end

  // R2
  done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_done);
  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> (!rsp_done && $stable(rsp_err) && $stable(rsp_amp) &&
                  $stable(rsp_scale) && $stable(rsp_emph)));
  // R3
  rate_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_rate_chg && (32'(req_rate) != RATE_CODE_LO) &&
     (32'(req_rate) != RATE_CODE_HI)) |=> rsp_err);
  // R4
  lane_cnt_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && (req_lanes != CNT_W'(1)) && (req_lanes != CNT_W'(2)) &&
     (req_lanes != CNT_W'(4))) |=> rsp_err);
  // R9
  err_zero_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> ((rsp_amp == '0) && (rsp_scale == '0) && (rsp_emph == '0)));
  // R9
  no_drv_chg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !req_drv_chg) |=> ((rsp_amp == '0) && (rsp_emph == '0)));

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane_chk
    logic [SUM_W-1:0] lvl_sum;
    assign lvl_sum = {1'b0, req_swing[g*LVL_W +: LVL_W]} +
                     {1'b0, req_preemph[g*LVL_W +: LVL_W]};
    // R5
    level_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && req_drv_chg && lane_act[g] && (lvl_sum > SUM_W'(MAX_LVL))) |=> rsp_err);
    // R7
    scale_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && req_drv_chg && lane_act[g] && !req_err)
        |=> (rsp_scale[g*SCALE_W +: SCALE_W] == SCALE_W'(1)));
    // R8
    idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && (int'(req_lanes) <= g))
        |=> ((rsp_amp[g*AMP_W +: AMP_W] == '0) && (rsp_scale[g*SCALE_W +: SCALE_W] == '0) &&
             (rsp_emph[g*EMPH_W +: EMPH_W] == '0)));
  end

endmodule

// File: tb/link_cfg_check_tb.sv
module link_cfg_check_tb;

  localparam int NL = 4;
  localparam int RW = 12;
  localparam int CW = 3;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_vld;
  logic          req_rate_chg;
  logic [RW-1:0] req_rate;
  logic [CW-1:0] req_lanes;
  logic          req_drv_chg;
  logic [NL*LW-1:0] req_swing;
  logic [NL*LW-1:0] req_preemph;
  logic          rsp_done;
  logic          rsp_err;
  logic [NL*3-1:0] rsp_amp;
  logic [NL*2-1:0] rsp_scale;
  logic [NL*4-1:0] rsp_emph;

  int errs = 0;
  int checks = 0;

  always #10 clk = ~clk;

  link_cfg_check #(.NUM_LANES(NL), .RATE_W(RW), .CNT_W(CW), .LVL_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_rate_chg(req_rate_chg),
    .req_rate(req_rate), .req_lanes(req_lanes), .req_drv_chg(req_drv_chg),
    .req_swing(req_swing), .req_preemph(req_preemph), .rsp_done(rsp_done),
    .rsp_err(rsp_err), .rsp_amp(rsp_amp), .rsp_scale(rsp_scale), .rsp_emph(rsp_emph)
  );

  function automatic int ref_amp(input int s, input int p);
    case (s)
      0: return 1 + p;
      1: return (p == 0) ? 3 : ((p == 1) ? 5 : 6);
      2: return (p == 0) ? 5 : 7;
      default: return 7;
    endcase
  endfunction

  function automatic int ref_emph(input int s, input int p);
    if (p == 0) return 0;
    case (s)
      0: return (p == 1) ? 4 : ((p == 2) ? 8 : 13);
      1: return (p == 1) ? 7 : 6;
      default: return 4;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_req(input string tag, input logic rc, input logic [RW-1:0] rate,
                         input logic [CW-1:0] ln, input logic dc,
                         input logic [NL*LW-1:0] sw, input logic [NL*LW-1:0] pe,
                         input bit hold);
    logic bad;
    logic [NL*3-1:0] e_amp;
    logic [NL*2-1:0] e_scale;
    logic [NL*4-1:0] e_emph;
    int n;
    @(negedge clk);
    req_rate_chg = rc; req_rate = rate; req_lanes = ln; req_drv_chg = dc;
    req_swing = sw; req_preemph = pe; req_vld = 1'b1;
    @(negedge clk);
    req_vld = 1'b0;
    n = int'(ln);
    bad = 1'b0;
    if (rc && rate != 12'h654 && rate != 12'hA8C) bad = 1'b1;
    if (!(n == 1 || n == 2 || n == 4)) bad = 1'b1;
    else if (dc) begin
      for (int i = 0; i < n; i++) begin
        int s, p;
        s = int'(sw[i*LW +: LW]);
        p = int'(pe[i*LW +: LW]);
        if (s > 3 || p > 3 || s + p > 3) bad = 1'b1;
      end
    end
    e_amp = '0; e_scale = '0; e_emph = '0;
    if (!bad && dc) begin
      for (int i = 0; i < n; i++) begin
        int s, p;
        s = int'(sw[i*LW +: LW]);
        p = int'(pe[i*LW +: LW]);
        e_amp[i*3 +: 3]   = 3'(ref_amp(s, p));
        e_scale[i*2 +: 2] = 2'd1;
        e_emph[i*4 +: 4]  = 4'(ref_emph(s, p));
      end
    end
    chk({tag, " R2 done"}, 64'(rsp_done), 64'd1);
    chk({tag, " err"}, 64'(rsp_err), 64'(bad));
    chk({tag, " codes"}, 64'({rsp_amp, rsp_scale, rsp_emph}), 64'({e_amp, e_scale, e_emph}));
    if (hold) begin
      req_rate_chg = 1'b1; req_rate = 12'h000; req_lanes = 3'd3;
      req_swing = '1; req_preemph = '1;
      @(negedge clk);
      chk({tag, " R2 done low"}, 64'(rsp_done), 64'd0);
      chk({tag, " R2 hold"}, 64'({rsp_err, rsp_amp, rsp_scale, rsp_emph}),
          64'({bad, e_amp, e_scale, e_emph}));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [RW-1:0] rates [8];
    rates = '{12'h654, 12'hA8C, 12'h653, 12'h655, 12'hA8B, 12'hA8D, 12'h000, 12'hFFF};
    rst_n = 1'b0; req_vld = 1'b0; req_rate_chg = 1'b0; req_rate = '0;
    req_lanes = '0; req_drv_chg = 1'b0; req_swing = '0; req_preemph = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", 64'({rsp_done, rsp_err, rsp_amp, rsp_scale, rsp_emph}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 after reset", 64'({rsp_done, rsp_err, rsp_amp, rsp_scale, rsp_emph}), 64'd0);

    // R4: every lane count with and without a drive change
    for (int ln = 0; ln < 8; ln++) begin
      run_req("R4 R8 lane count", 1'b0, 12'h000, 3'(ln), 1'b1, '0, '0, 1'b1);
      run_req("R4 R9 lane count no drive", 1'b0, 12'h000, 3'(ln), 1'b0, '0, '0, 1'b0);
    end

    // R3: rate codes around the two accepted values, flag on and off
    for (int k = 0; k < 8; k++) begin
      run_req("R3 rate check", 1'b1, rates[k], 3'd4, 1'b1, 12'o0123, 12'o1210, 1'b0);
      run_req("R3 rate ignored", 1'b0, rates[k], 3'd2, 1'b1, 12'o0012, 12'o0001, 1'b0);
    end

    // R5 R6 R7: every pair on every lane, other lanes valid
    for (int ln = 0; ln < NL; ln++) begin
      for (int s = 0; s < 8; s++) begin
        for (int p = 0; p < 8; p++) begin
          logic [NL*LW-1:0] sw, pe;
          sw = '0; pe = '0;
          sw[ln*LW +: LW] = 3'(s);
          pe[ln*LW +: LW] = 3'(p);
          run_req("R5 R6 R7 pair sweep", 1'b1, 12'hA8C, 3'd4, 1'b1, sw, pe, 1'b0);
        end
      end
    end

    // R8: idle lanes with illegal levels are ignored
    run_req("R8 one lane", 1'b0, 12'h000, 3'd1, 1'b1, 12'o7772, 12'o7770, 1'b1);
    run_req("R8 two lanes", 1'b1, 12'h654, 3'd2, 1'b1, 12'o7701, 12'o7721, 1'b1);
    run_req("R8 active lane bad", 1'b0, 12'h000, 3'd2, 1'b1, 12'o0040, 12'o0000, 1'b1);

    // R9: rejection and no drive change both give zero codes
    run_req("R9 no drive change", 1'b1, 12'h654, 3'd4, 1'b0, 12'o3210, 12'o0123, 1'b1);
    run_req("R9 rate error", 1'b1, 12'h123, 3'd4, 1'b1, 12'o3210, 12'o0011, 1'b1);
    run_req("R6 mixed lanes", 1'b1, 12'hA8C, 3'd4, 1'b1, 12'o3210, 12'o0012, 1'b1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule